// File: doc/BRIEF.md
# SPI Port with Write-Collision Detection

A byte-wide synchronous serial port that works either as the clock-driving end (master) or as the clock-receiving end (slave) of an SPI link. One 8-bit shift register carries data in both directions, most significant bit first. It is reached only through a single data buffer register: writing the buffer loads the shifter, and a finished byte is copied back into the buffer. Completion raises a buffer-full bit and an interrupt flag. A buffer write made while a byte is still moving is dropped and latches a write-collision bit, which stays set until software clears it.

The port has four word addresses. Address 0 is the data buffer. Address 1 is the control register. Address 2 is the read-only status register. A write of any value to address 3 clears the interrupt flag. In master mode a buffer write made while idle starts a transfer, and the serial clock is made by dividing the system clock. In slave mode the serial clock, data input and select input come from outside and pass through two-flop synchronizers. The select input can be configured to gate the port.

Top module: `spi_port`

## Requirements
- R1: After reset the buffer, the control register, the status register, `irq` and `sck_oe` all read 0.
- R2: Control is laid out as bits[1:0] rate, [2] master, [3] clock idle level, [4] edge select, [5] end sampling, [6] select enable, [7] write collision. Status is laid out as [0] buffer full, [1] interrupt, [2] busy. In master mode a buffer write made while idle sends the byte on `sdo` MSB first and captures 8 bits from `sdi`. At the end the received byte is in the buffer, busy is 0, and buffer full and interrupt are both 1.
- R3: `sck_o` rests at the idle level set in bit 3. With edge select 0, output data changes on the active-to-idle SCK edge and the middle sample is taken on the idle-to-active edge. With edge select 1 these two edges swap roles.
- R4: In master mode end sampling (bit 5 = 1) captures `sdi` at the end of each bit time, on the same edge where output changes. Bit 5 = 0 captures it at the middle edge.
- R5: A master SCK half period lasts 2, 8 or 32 system clocks for rate 0, 1 or 2. Rate 3 behaves as rate 2.
- R6: Reading the buffer clears buffer full. Buffer full cannot be written.
- R7: The interrupt flag and `irq` stay set after the buffer is read, and clear only on a write to address 3.
- R8: A buffer write made while busy is dropped. It leaves the ongoing transfer and the buffer contents unchanged and sets control bit 7.
- R9: Control bit 7 stays set until a control write with bit 7 = 0 clears it. A control write with bit 7 = 1 does not clear it.
- R10: In slave mode `sck_oe` is 0 and the port shifts on the synchronized `sck_i`. It samples on the middle edge and updates `sdo` on the launch edge, both chosen by the edge select bit of R3. After the 8th middle edge the byte is in the buffer and buffer full and interrupt are set.
- R11: In slave mode with select enable set and `ss_n` high, `sdo_oe` is 0 and SCK edges move no bits. No transfer completes, busy stays 0 and the buffer is kept.
- R12: Raising `ss_n` mid-byte (select enabled) clears the bit count, so busy drops. The next full byte is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (buffer read clears buffer full) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt flag |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low |

## Verification
Master transfers run with every combination of idle level and edge select, and at all four rate codes. Measuring the half period tells the dividers apart, and distinct byte pairs show the direction and bit order of both shift paths. For end sampling the peer changes its data late, on the middle edge, so only a capture at the end of the bit returns the right byte. Slave transfers run under both edge selects. Separate runs hold select high through clock pulses and raise it after three bits, which separates true gating from a port that keeps counting.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sdi,
  input  logic       ss_n
);
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [7:0] dbuf, sr;
  logic [1:0] rate;
  logic master, cpol, esel, smp_end, ss_en, wcol;
  logic bf, irq_q, busy_m, sdo_q, half;
  logic [CW-1:0] cnt;
  logic [5:0] tmr, hlim;
  logic [2:0] sck_s;
  logic [1:0] ss_s, sdi_s;

  wire wr_buf = reg_wr && reg_addr == 2'd0;
  wire wr_ctl = reg_wr && reg_addr == 2'd1;
  wire wr_clr = reg_wr && reg_addr == 2'd3;
  wire rd_buf = reg_rd && reg_addr == 2'd0;

  wire gate     = ss_en & ss_s[1];
  wire s_edge   = ~master & ~gate & (sck_s[1] ^ sck_s[2]);
  wire s_act    = sck_s[1] ^ cpol;
  wire s_mid    = s_edge & (s_act ^ esel);
  wire s_launch = s_edge & ~(s_act ^ esel);

  always_comb
    case (rate)
      2'd0:    hlim = 6'd1;
      2'd1:    hlim = 6'd7;
      default: hlim = 6'd31;
    endcase

  wire tick  = busy_m && tmr == hlim;
  wire m_mid = tick & ~half;
  wire m_end = tick & half;

  wire busy  = master ? busy_m : (cnt != '0);
  wire start = wr_buf & ~busy;
  wire samp  = master ? (smp_end ? m_end : m_mid) : s_mid;
  wire laun  = master ? m_end : s_launch;
  wire done  = (master ? m_end : s_mid) && cnt == LAST;
  wire [7:0] sr_nx = {sr[6:0], master ? sdi : sdi_s[1]};
  wire [7:0] rx    = (master && !smp_end) ? sr : sr_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ss_s  <= {ss_s[0], ss_n};
      sdi_s <= {sdi_s[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {wcol, ss_en, smp_end, esel, cpol, master, rate} <= '0;
      dbuf <= '0; sr <= '0; sdo_q <= 1'b0;
      bf <= 1'b0; irq_q <= 1'b0; busy_m <= 1'b0;
      half <= 1'b0; tmr <= '0; cnt <= '0;
    end else begin
      if (wr_ctl) {ss_en, smp_end, esel, cpol, master, rate} <= reg_wdata[6:0];

      if (wr_buf && busy)          wcol <= 1'b1;
      else if (wr_ctl && !reg_wdata[7]) wcol <= 1'b0;

      if (start) begin
        dbuf  <= reg_wdata;
        sr    <= reg_wdata;
        sdo_q <= reg_wdata[7];
      end else begin
        if (samp) sr <= sr_nx;
        if (laun) sdo_q <= samp ? sr[6] : sr[7];
      end
      if (done) dbuf <= rx;

      if (done)        bf <= 1'b1;
      else if (rd_buf) bf <= 1'b0;

      if (done)        irq_q <= 1'b1;
      else if (wr_clr) irq_q <= 1'b0;

      if (start && master) begin
        busy_m <= 1'b1; tmr <= '0; half <= 1'b0; cnt <= '0;
      end else if (master) begin
        if (tick) begin
          tmr  <= '0;
          half <= ~half;
          if (half) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) busy_m <= 1'b0;
          end
        end else if (busy_m) tmr <= tmr + 1'b1;
      end else if (gate)  cnt <= '0;
      else if (s_mid)     cnt <= cnt + 1'b1;
    end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = dbuf;
      2'd1:    reg_rdata = {wcol, ss_en, smp_end, esel, cpol, master, rate};
      2'd2:    reg_rdata = {5'd0, busy, irq_q, bf};
      default: reg_rdata = '0;
    endcase

  assign irq    = irq_q;
  assign sck_o  = cpol ^ (busy_m & (esel ? ~half : half));
  assign sck_oe = master;
  assign sdo    = sdo_q;
  assign sdo_oe = master | ~gate;

  p_done_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> bf && irq_q);
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy_m) |-> sck_o == cpol);
  p_bf_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !bf);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_clr) |=> irq_q);
  p_drop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && busy) |=> wcol);
  p_drop_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && busy && !done) |=> $stable(dbuf));
  p_wcol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !(wr_ctl && !reg_wdata[7])) |=> wcol);
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !wr_ctl && ss_en && ss_s[1]) |=> cnt == '0);
endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int CLK_P = 10;
  localparam int SHP = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, sck_o, sck_oe, sck_i = 0, sdo, sdo_oe, sdi, ss_n = 1;
  logic m_sdi = 0, s_sdi = 0, slave_tb = 0;
  assign sdi = slave_tb ? s_sdi : m_sdi;

  spi_port dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdi(sdi), .ss_n(ss_n));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  // scoreboard: driver pushes expected serial bytes, monitor compares them
  logic [7:0] exp_q[$];
  logic [7:0] peer_b = 0, cap = 0;
  logic mon_en = 0, m_cpol = 0, m_esel = 0, late = 0;
  int pk = 0, mk = 0, t_prev = 0, t_last = 0;

  always @(sck_o) begin
    if (mon_en) begin
      t_prev = t_last; t_last = cyc;
      if (((sck_o ^ m_cpol) ^ m_esel) == 1'b1) begin
        cap = {cap[6:0], sdo};
        if (late) begin if (pk < 8) m_sdi = peer_b[7-pk]; pk++; end
        mk++;
        if (mk == 8) begin
          mk = 0;
          if (exp_q.size() == 0) chk("R2 scoreboard empty", 1, 0);
          else chk("R2 serial out", cap, exp_q.pop_front());
        end
      end else if (!late) begin
        if (m_esel) begin if (pk < 8) m_sdi = peer_b[7-pk]; pk++; end
        else begin pk++; if (pk < 8) m_sdi = peer_b[7-pk]; end
      end
    end
  end

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, s);
      if (!s[2]) break;
    end
  endtask

  task automatic mxfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] pb,
                       input logic lt, input int h, input string req);
    logic [7:0] d;
    wr(2'd1, ctl);
    m_cpol = ctl[3]; m_esel = ctl[4]; late = lt; peer_b = pb; pk = 0; mk = 0;
    m_sdi = lt ? ~pb[7] : pb[7];
    @(negedge clk); mon_en = 1;
    exp_q.push_back(tx);
    wr(2'd0, tx);
    wait_idle();
    mon_en = 0;
    rd(2'd2, d); chk("R2 flags after transfer", d, 8'h03);
    rd(2'd0, d); chk({req, " received byte"}, d, pb);
    chk("R5 half period", t_last - t_prev, h);
    rd(2'd2, d); chk("R6 buffer full cleared by read", d[0], 0);
    chk("R7 irq held after read", irq, 1);
    wr(2'd3, 8'h00);
    chk("R7 irq cleared by strobe", irq, 0);
  endtask

  task automatic sxfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] d, got;
    wr(2'd1, ctl);
    wr(2'd0, tx);
    chk("R10 sck_oe off in slave", sck_oe, 0);
    got = 0;
    for (int i = 0; i < 8; i++) begin
      s_sdi = rx[7-i];
      if (ctl[4]) begin
        sck_i = 1; repeat (SHP) @(negedge clk);
        got = {got[6:0], sdo};
        sck_i = 0; repeat (SHP) @(negedge clk);
      end else begin
        repeat (SHP) @(negedge clk);
        got = {got[6:0], sdo};
        sck_i = 1; repeat (SHP) @(negedge clk);
        sck_i = 0;
      end
    end
    repeat (SHP) @(negedge clk);
    chk("R10 slave serial out", got, tx);
    rd(2'd2, d); chk("R10 slave flags", d, 8'h03);
    rd(2'd0, d); chk("R10 slave received byte", d, rx);
    wr(2'd3, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, d); chk("R1 buffer reset", d, 0);
    rd(2'd1, d); chk("R1 control reset", d, 0);
    rd(2'd2, d); chk("R1 status reset", d, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 sck_oe reset", sck_oe, 0);

    mxfer(8'h04, 8'hA5, 8'h3C, 0, 2,  "R2 mode idle0 edge0");
    mxfer(8'h1D, 8'h81, 8'h7E, 0, 8,  "R3 mode idle1 edge1");
    mxfer(8'h0C, 8'h6E, 8'hB1, 0, 2,  "R3 mode idle1 edge0");
    mxfer(8'h14, 8'h2D, 8'hD4, 0, 2,  "R3 mode idle0 edge1");
    mxfer(8'h26, 8'h5A, 8'hC6, 1, 32, "R4 end sampling late peer");
    mxfer(8'h07, 8'h0F, 8'hF0, 0, 32, "R5 rate code 3");

    // R8 / R9 write collision
    wr(2'd1, 8'h05);
    m_cpol = 0; m_esel = 0; late = 0; peer_b = 8'h99; pk = 0; mk = 0; m_sdi = 1;
    @(negedge clk); mon_en = 1;
    exp_q.push_back(8'h3C);
    wr(2'd0, 8'h3C);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'hFF);
    rd(2'd1, d); chk("R8 collision bit set", d[7], 1);
    wait_idle();
    mon_en = 0;
    rd(2'd0, d); chk("R8 dropped write kept out of buffer", d, 8'h99);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    wr(2'd1, 8'h85);
    rd(2'd1, d); chk("R9 collision kept on write of 1", d[7], 1);
    wr(2'd1, 8'h05);
    rd(2'd1, d); chk("R9 collision cleared", d[7], 0);
    wr(2'd3, 8'h00);

    // slave mode
    slave_tb = 1;
    sxfer(8'h00, 8'h96, 8'h4B);
    sxfer(8'h10, 8'h3A, 8'hE5);

    // R11 gating
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h11);
    ss_n = 1;
    repeat (4) @(negedge clk);
    chk("R11 sdo released while deselected", sdo_oe, 0);
    for (int i = 0; i < 8; i++) begin
      s_sdi = i[0];
      sck_i = 1; repeat (SHP) @(negedge clk);
      sck_i = 0; repeat (SHP) @(negedge clk);
    end
    rd(2'd2, d); chk("R11 no transfer while deselected", d, 0);
    rd(2'd0, d); chk("R11 buffer kept", d, 8'h11);
    ss_n = 0;
    repeat (4) @(negedge clk);
    chk("R11 sdo driven when selected", sdo_oe, 1);

    // R12 mid-byte deselect
    for (int i = 0; i < 3; i++) begin
      s_sdi = 1;
      repeat (SHP) @(negedge clk); sck_i = 1;
      repeat (SHP) @(negedge clk); sck_i = 0;
    end
    repeat (4) @(negedge clk);
    rd(2'd2, d); chk("R12 busy after partial byte", d[2], 1);
    ss_n = 1; repeat (6) @(negedge clk);
    rd(2'd2, d); chk("R12 count cleared by deselect", d[2], 0);
    ss_n = 0; repeat (6) @(negedge clk);
    sxfer(8'h40, 8'h5C, 8'hC3);

    finish_run();
  end
endmodule